// File: doc/BRIEF.md
# One-Time-Programmable Fuse Register Interface

This block is the register front end of a one-time-programmable fuse store whose main job is to hand a factory serial number to boot software. A 32-bit register bus with separate read and write strobes reaches fifteen word registers. Fourteen of them are plain control registers. One is a read-only data port that returns a fuse word, but only while three separate enable registers are all switched on.

The fuse array is a parameterised number of 32-bit words. After reset, every word reads as all ones except two neighbouring words. One of them holds the serial value given as a parameter, and the word after it holds the bitwise inverse of that value, so software can check the serial. Burning fuses, analog timing and programming pulses are not modelled. The program, test and strobe registers only store what software writes into them.

Register map (byte offsets, one register per 32-bit word): 0x00 fuse address, 0x04 address I/O, 0x08 address strobe, 0x0C chip enable, 0x10 clock control, 0x14 data in, 0x18 data out, 0x1C data strobe, 0x20 program, 0x24 test control, 0x28 test mode, 0x2C test repeat, 0x30 test read, 0x34 trim, 0x38 write enable.

Top module: `otp_fuse_regif`

## Requirements
- R1: After reset every control register reads 0, and the data-out register at 0x18 reads 0x000000FF.
- R2: Each register other than the fuse address and data out reads back the full 32-bit value last written to it.
- R3: A write to the fuse address register at 0x00 keeps only the low log2(FUSE_DEPTH) bits (0xFFF by default) and clears the rest.
- R4: A read of 0x18 returns the fuse word indexed by the fuse address register when bit 0 of chip enable (0x0C), data strobe (0x1C) and trim (0x34) are all 1. Otherwise it returns 0x000000FF.
- R5: Every fuse word reads 0xFFFFFFFF, except that the word at SERIAL_ADDR (0xFC by default) holds SERIAL and the next word (index wrapping within the array) holds ~SERIAL.
- R6: A write to 0x18 changes no register and no later read result.
- R7: A read from an unmapped offset (0x3C and above, or any address with bits 1:0 not zero) returns 0. A write to such an address changes no register.
- R8: Read data appears on bus_rdata on the clock edge that samples bus_rd, and stays unchanged in the cycles without a read.
- R9: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.
- R10: Only bit 0 of the chip enable, data strobe and trim registers takes part in the data-out enable. A value with bit 0 clear, such as 0xFFFFFFFE, disables the data-out read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |

## Verification
The embedded properties take for granted that bus_rd and bus_wr are never X after reset, and that bus_addr and bus_wdata are stable around the sampling edge of any cycle in which a strobe is high. A read and a write may share a cycle, and the properties still hold. The bench changes every input only on the falling clock edge and raises each strobe for exactly one cycle. It samples bus_rdata on the following falling edge, so each strobe reaches the design as one clean, single-cycle request.

// File: rtl/otp_pkg.sv
package otp_pkg;
   localparam int DATA_W   = 32;
   localparam int NUM_REGS = 15;

   // word slots; the data-out gating depends on the fixed slots below
   localparam int SLOT_ADDR      = 0;
   localparam int SLOT_ADDR_IO   = 1;
   localparam int SLOT_ADDR_STB  = 2;
   localparam int SLOT_CHIP_EN   = 3;
   localparam int SLOT_CLK_CTL   = 4;
   localparam int SLOT_DATA_IN   = 5;
   localparam int SLOT_DATA_OUT  = 6;
   localparam int SLOT_DATA_STB  = 7;
   localparam int SLOT_PROG      = 8;
   localparam int SLOT_TEST_CTL  = 9;
   localparam int SLOT_TEST_MODE = 10;
   localparam int SLOT_TEST_REP  = 11;
   localparam int SLOT_TEST_RD   = 12;
   localparam int SLOT_TRIM      = 13;
   localparam int SLOT_WR_EN     = 14;

   localparam logic [DATA_W-1:0] IDLE_READ = 32'h0000_00FF;
   localparam logic [DATA_W-1:0] BLANK_FUSE = '1;

   typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec
   import otp_pkg::*;
#(
   parameter int BUS_AW = 8,
   parameter int NREG   = NUM_REGS,
   localparam int IW    = $clog2(NREG),
   localparam int WW    = BUS_AW - 2
) (
   input  logic [BUS_AW-1:0] addr,
   output logic              hit,
   output logic [IW-1:0]     slot
);
   logic [WW-1:0] word;
   logic          aligned;

   assign word    = addr[BUS_AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign hit     = aligned && (word <= WW'(NREG - 1));
   assign slot    = word[IW-1:0];
endmodule

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
   import otp_pkg::*;
#(
   parameter int NREG    = NUM_REGS,
   parameter int FUSE_AW = 12,
   localparam int IW     = $clog2(NREG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic                         hit,
   input  logic [IW-1:0]                slot,
   input  word_t                        wdata,
   output logic [NREG-1:0][DATA_W-1:0]  regs
);
   localparam word_t ADDR_KEEP = word_t'((64'd1 << FUSE_AW) - 64'd1);

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_slot
         logic sel;
         assign sel = wr && hit && (slot == IW'(g));
         if (g == SLOT_DATA_OUT) begin : g_ro
            // read-only slot: the read mux supplies its value
            assign regs[g] = '0;
         end else if (g == SLOT_ADDR) begin : g_addr
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   regs[g] <= '0;
               else if (sel) regs[g] <= wdata & ADDR_KEEP;
            end
            // R3: stored address keeps only the index bits of the write
            p_addr_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
               sel |=> regs[g] == ($past(wdata) & ADDR_KEEP));
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   regs[g] <= '0;
               else if (sel) regs[g] <= wdata;
            end
         end
      end
   endgenerate

   // R7: writes outside the map leave all registers alone
   p_drop_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !hit) |=> $stable(regs));
   // R6: a write to the data-out slot leaves all registers alone
   p_dout_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit && slot == IW'(SLOT_DATA_OUT)) |=> $stable(regs));
endmodule

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom
   import otp_pkg::*;
#(
   parameter int    FUSE_AW     = 12,
   parameter int    SERIAL_ADDR = 'hFC,
   parameter word_t SERIAL      = '0,
   parameter bit    SERIAL_EN   = 1'b1
) (
   input  logic [FUSE_AW-1:0] idx,
   output word_t              fuse
);
   localparam logic [FUSE_AW-1:0] SER_IDX = FUSE_AW'(SERIAL_ADDR);
   localparam logic [FUSE_AW-1:0] CHK_IDX = FUSE_AW'(SERIAL_ADDR + 1);

   generate
      if (SERIAL_EN) begin : g_serial
         always_comb begin
            if (idx == SER_IDX)      fuse = SERIAL;
            else if (idx == CHK_IDX) fuse = ~SERIAL;
            else                     fuse = BLANK_FUSE;
         end
      end else begin : g_blank
         assign fuse = BLANK_FUSE;
      end
   endgenerate
endmodule

// File: rtl/otp_rd_mux.sv
module otp_rd_mux
   import otp_pkg::*;
#(
   parameter int NREG   = NUM_REGS,
   parameter int EN_BIT = 0,
   localparam int IW    = $clog2(NREG)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd,
   input  logic                        hit,
   input  logic [IW-1:0]               slot,
   input  logic [NREG-1:0][DATA_W-1:0] regs,
   input  word_t                       fuse,
   output word_t                       rdata
);
   logic  dout_en;
   word_t rd_next;

   assign dout_en = regs[SLOT_CHIP_EN][EN_BIT]
                  & regs[SLOT_DATA_STB][EN_BIT]
                  & regs[SLOT_TRIM][EN_BIT];

   always_comb begin
      if (!hit)                             rd_next = '0;
      else if (slot == IW'(SLOT_DATA_OUT))  rd_next = dout_en ? fuse : IDLE_READ;
      else                                  rd_next = regs[slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_next;
   end

   // R8: no read, no change on the read bus
   p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));
   // R7: unmapped reads give zero
   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !hit) |=> rdata == '0);
   // R4: data-out with any enable low gives the idle pattern
   p_dout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit && slot == IW'(SLOT_DATA_OUT) &&
       !(regs[SLOT_CHIP_EN][EN_BIT] && regs[SLOT_DATA_STB][EN_BIT] &&
         regs[SLOT_TRIM][EN_BIT])) |=> rdata == IDLE_READ);
endmodule

// File: rtl/otp_fuse_regif.sv
module otp_fuse_regif
   import otp_pkg::*;
#(
   parameter int    BUS_AW      = 8,
   parameter int    FUSE_DEPTH  = 4096,
   parameter int    SERIAL_ADDR = 'hFC,
   parameter word_t SERIAL      = '0,
   parameter bit    SERIAL_EN   = 1'b1,
   parameter int    EN_BIT      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata
);
   localparam int FUSE_AW = $clog2(FUSE_DEPTH);
   localparam int IW      = $clog2(NUM_REGS);

   generate
      if ((FUSE_DEPTH < 2) || ((FUSE_DEPTH & (FUSE_DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("FUSE_DEPTH must be a power of two of at least 2");
      end
      if ((SERIAL_ADDR < 0) || (SERIAL_ADDR >= FUSE_DEPTH)) begin : g_bad_serial
         $error("SERIAL_ADDR must lie inside the fuse array");
      end
      if (BUS_AW < 6) begin : g_bad_bus
         $error("BUS_AW too narrow for the register map");
      end
      if ((EN_BIT < 0) || (EN_BIT >= DATA_W)) begin : g_bad_en
         $error("EN_BIT outside the data word");
      end
   endgenerate

   logic                          hit;
   logic [IW-1:0]                 slot;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   word_t                         fuse;

   otp_addr_dec #(.BUS_AW(BUS_AW), .NREG(NUM_REGS)) u_dec (
      .addr (bus_addr),
      .hit  (hit),
      .slot (slot)
   );

   otp_ctrl_regs #(.NREG(NUM_REGS), .FUSE_AW(FUSE_AW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .hit   (hit),
      .slot  (slot),
      .wdata (bus_wdata),
      .regs  (regs)
   );

   otp_fuse_rom #(
      .FUSE_AW     (FUSE_AW),
      .SERIAL_ADDR (SERIAL_ADDR),
      .SERIAL      (SERIAL),
      .SERIAL_EN   (SERIAL_EN)
   ) u_rom (
      .idx  (regs[SLOT_ADDR][FUSE_AW-1:0]),
      .fuse (fuse)
   );

   otp_rd_mux #(.NREG(NUM_REGS), .EN_BIT(EN_BIT)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .hit   (hit),
      .slot  (slot),
      .regs  (regs),
      .fuse  (fuse),
      .rdata (bus_rdata)
   );

   // R9: read paired with a write to the same register returns the old value
   p_read_before_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr && hit && slot == IW'(SLOT_DATA_IN))
      |=> bus_rdata == $past(regs[SLOT_DATA_IN]));
endmodule

// File: tb/otp_fuse_regif_bench.sv
module otp_fuse_regif_bench;
   localparam logic [31:0] SER  = 32'hA5C3_0F96;
   localparam logic [31:0] NSER = 32'h5A3C_F069;

   typedef struct packed {
      logic        rd;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'h0, 32'h0000_0000, 4'd1},  // R1 address reset
      '{1'b1, 8'h0C, 32'h0, 32'h0000_0000, 4'd1},  // R1 chip enable reset
      '{1'b1, 8'h18, 32'h0, 32'h0000_00FF, 4'd1},  // R1 data out idle
      '{1'b0, 8'h14, 32'hDEAD_BEEF, 32'h0, 4'd2},
      '{1'b1, 8'h14, 32'h0, 32'hDEAD_BEEF, 4'd2},  // R2 data in
      '{1'b0, 8'h2C, 32'h8000_0001, 32'h0, 4'd2},
      '{1'b1, 8'h2C, 32'h0, 32'h8000_0001, 4'd2},  // R2 test repeat
      '{1'b0, 8'h20, 32'h5A5A_5A5A, 32'h0, 4'd2},
      '{1'b1, 8'h20, 32'h0, 32'h5A5A_5A5A, 4'd2},  // R2 program
      '{1'b0, 8'h00, 32'hFFFF_F0FC, 32'h0, 4'd3},
      '{1'b1, 8'h00, 32'h0, 32'h0000_00FC, 4'd3},  // R3 masking
      '{1'b0, 8'h0C, 32'h1, 32'h0, 4'd4},
      '{1'b0, 8'h1C, 32'h1, 32'h0, 4'd4},
      '{1'b1, 8'h18, 32'h0, 32'h0000_00FF, 4'd4},  // R4 trim still off
      '{1'b0, 8'h34, 32'h1, 32'h0, 4'd4},
      '{1'b1, 8'h18, 32'h0, SER, 4'd5},            // R5 serial word
      '{1'b0, 8'h00, 32'hFD, 32'h0, 4'd5},
      '{1'b1, 8'h18, 32'h0, NSER, 4'd5},           // R5 complement word
      '{1'b0, 8'h00, 32'h0, 32'h0, 4'd5},
      '{1'b1, 8'h18, 32'h0, 32'hFFFF_FFFF, 4'd5},  // R5 blank word
      '{1'b0, 8'h18, 32'h1234_5678, 32'h0, 4'd6},
      '{1'b1, 8'h18, 32'h0, 32'hFFFF_FFFF, 4'd6},  // R6 data out unchanged
      '{1'b1, 8'h00, 32'h0, 32'h0000_0000, 4'd6},  // R6 address unchanged
      '{1'b0, 8'h34, 32'hFFFF_FFFE, 32'h0, 4'd10},
      '{1'b1, 8'h18, 32'h0, 32'h0000_00FF, 4'd10}, // R10 only bit 0 counts
      '{1'b0, 8'h3C, 32'h1111_1111, 32'h0, 4'd7},
      '{1'b1, 8'h3C, 32'h0, 32'h0, 4'd7},          // R7 unmapped read
      '{1'b1, 8'h14, 32'h0, 32'hDEAD_BEEF, 4'd7},  // R7 write dropped
      '{1'b1, 8'h01, 32'h0, 32'h0, 4'd7},          // R7 misaligned read
      '{1'b0, 8'h05, 32'h77, 32'h0, 4'd7},
      '{1'b1, 8'h04, 32'h0, 32'h0, 4'd7},          // R7 misaligned write dropped
      '{1'b1, 8'hFC, 32'h0, 32'h0, 4'd7},          // R7 top of space
      '{1'b0, 8'h38, 32'hCAFE_F00D, 32'h0, 4'd2},
      '{1'b1, 8'h38, 32'h0, 32'hCAFE_F00D, 4'd2}   // R2 write enable reg
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   otp_fuse_regif #(.SERIAL(SER)) u_otp_fuse_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input int req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] q);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      q = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] q;
      repeat (3) @(negedge clk);
      check(bus_rdata, 32'h0, 1);   // R1 read bus after reset
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            do_read(VEC[i].a, q);
            check(q, VEC[i].e, int'(VEC[i].req));
         end else begin
            do_write(VEC[i].a, VEC[i].d);
         end
      end

      // R8: read data holds while no read is issued
      repeat (3) @(negedge clk);
      check(bus_rdata, 32'hCAFE_F00D, 8);

      // R9: read and write on the same register in one cycle
      @(negedge clk);
      bus_addr = 8'h14; bus_wdata = 32'h0BAD_CAFE; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check(bus_rdata, 32'hDEAD_BEEF, 9);
      do_read(8'h14, q);
      check(q, 32'h0BAD_CAFE, 9);

      // R4: all enables on, walk away from serial and back
      do_write(8'h34, 32'h1);
      do_write(8'h00, 32'h1FC);
      do_read(8'h18, q);
      check(q, 32'hFFFF_FFFF, 4);
      do_write(8'h00, 32'h0FC);
      do_read(8'h18, q);
      check(q, SER, 4);

      // R1: reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(bus_rdata, 32'h0, 1);
      rst_n = 1'b1;
      do_read(8'h14, q);
      check(q, 32'h0, 1);
      do_read(8'h18, q);
      check(q, 32'h0000_00FF, 1);

      finish_run();
   end
endmodule